// File: doc/BRIEF.md
# SMBus Timeout and Bus-Idle Monitor

This block observes the clock and data lines of a two-wire SMBus segment and times four conditions in units of a baud tick: how long the bus has been quiet since the last STOP, how long the local controller has held the clock low in the current transaction, how long other devices have held the clock low, and how long the clock has stayed high while a transaction is open. The counting granularity comes from a one-cycle tick enable, so a clock divider elsewhere sets the absolute time base.

One 32-bit configuration word holds an 8-bit limit for each check. Each limit has its own fixed prescale, and the bus-idle limit also carries a x1/x4 range selector. A master sequencer waits on `bus_free` before it issues a START. It reacts to the per-check interrupt pulses and sticky flags, which software or the sequencer clears by writing ones. Line inputs are assumed to be synchronised to `clk` already.

The control core is a four-state bus tracker. SETTLE counts quiet ticks after a STOP or reset and moves to FREE once the idle limit is reached. FREE moves to BUSY on a START, or to HUNT if a line drops without a START. BUSY moves to SETTLE on a STOP, and a repeated START leaves it in BUSY. HUNT has lost track of the bus: it moves to BUSY on a START or to SETTLE on a STOP. Each of the three timeout channels is a small two-state timer. ARMED counts and moves to SPENT when its limit is reached. SPENT leaves only on a restart, which returns it to ARMED with a zero count.

Top module: `smb_tmo_mon`

## Requirements
- R1: The configuration word holds the bus-idle limit in bits 31:24, the controller cumulative limit in bits 23:16, the target cumulative limit in bits 15:8 and the clock-high limit in bits 7:0.
- R2: When the tick enable is held high, `bus_free` rises L+1 clock cycles after the edge that samples a STOP, where L = idle[6:0] x 4 if idle[7] is 1 and L = idle[6:0] if idle[7] is 0. A value of L = 0 gives a rise one cycle after the STOP.
- R3: A line falling while the bus is free, without forming a START, puts the tracker in HUNT. `bus_free` then stays low, even with both lines high, until a STOP has been seen and the idle time has run again.
- R4: `bus_free` goes low in the same cycle that SCL or SDA is low, with no clock edge needed.
- R5: The controller timer counts ticks in which a transaction is open, SCL is low and `ctl_scl_low` is 1. It keeps its count across SCL-high phases. When the count reaches field x 2048 it pulses `tmo_irq[0]` for one cycle, on the edge that takes the final tick.
- R6: The target timer counts ticks in which a transaction is open, SCL is low and `ctl_scl_low` is 0. It pulses `tmo_irq[1]` at field x 4096 ticks. Time charged to the target never advances the controller timer.
- R7: The clock-high timer counts ticks in which a transaction is open and SCL is high. It restarts whenever SCL is low, and it pulses `tmo_irq[2]` at field x 8 ticks.
- R8: A START or a STOP clears both cumulative counts to zero.
- R9: A limit field of zero disables its timeout: no pulse and no flag, however long the condition lasts.
- R10: No timer or idle count advances in a cycle where `tick_en` is 0.
- R11: Each `tmo_flag` bit is set on the edge after its interrupt pulse and stays set until a 1 is written on the matching `flag_clr` bit. If a set and a clear fall on the same edge, the set wins.
- R12: While reset is held, `bus_free`, `tmo_irq` and `tmo_flag` are all 0. The tracker leaves reset in SETTLE, so with both lines high it reaches FREE after the idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Baud tick, one cycle wide |
| cfg_word | input | 32 | Packed limits: idle, controller, target, clock-high |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| ctl_scl_low | input | 1 | High while the local controller pulls SCL low |
| flag_clr | input | 3 | Write-1-to-clear strobes for the sticky flags |
| bus_free | output | 1 | Bus idle long enough for a new START |
| tmo_irq | output | 3 | One-cycle timeout pulses: bit0 controller, bit1 target, bit2 clock-high |
| tmo_flag | output | 3 | Sticky timeout flags, same bit order |

## Verification
A timeout that is expiring can meet a write-1-to-clear on the same flag bit in the same clock edge. The bench provokes this by raising `flag_clr[0]` in the very cycle in which `tmo_irq[0]` is seen high. It then expects the flag to read 1 on the next sample, and to read 0 one cycle later once only the clear remains. A second overlap is a line falling in the same cycle the idle count completes. The bench covers it by requiring `bus_free` to be low in the cycle a line goes low.

// File: rtl/smb_mon_pkg.sv
`timescale 1ns/1ps
package smb_mon_pkg;

    typedef enum logic [1:0] {
        BS_SETTLE = 2'd0,
        BS_FREE   = 2'd1,
        BS_BUSY   = 2'd2,
        BS_HUNT   = 2'd3
    } bus_state_e;

    typedef enum logic {
        TM_ARMED = 1'b0,
        TM_SPENT = 1'b1
    } tmr_state_e;

    localparam int NUM_TMO = 3;
    localparam int CH_CTL  = 0;
    localparam int CH_TGT  = 1;
    localparam int CH_HIGH = 2;

endpackage

// File: rtl/smb_cond_detect.sv
`timescale 1ns/1ps
module smb_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // SDA moving while SCL is steadily high marks a bus condition
    always_comb begin
        start_det = scl_q & scl & sda_q & ~sda;
        stop_det  = scl_q & scl & ~sda_q & sda;
    end
endmodule

// File: rtl/smb_bus_fsm.sv
`timescale 1ns/1ps
module smb_bus_fsm
    import smb_mon_pkg::*;
#(
    parameter int FIELD_W       = 8,
    parameter int IDLE_X4_SHIFT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               scl,
    input  logic               sda,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [FIELD_W-1:0] idle_field,
    output logic               bus_free,
    output logic               busy
);
    localparam int LW = FIELD_W - 1 + IDLE_X4_SHIFT;

    bus_state_e    state_q;
    bus_state_e    state_d;
    logic [LW-1:0] idle_cnt;
    logic [LW-1:0] idle_base;
    logic [LW-1:0] idle_lim;
    logic          lines_high;

    always_comb begin
        idle_base  = LW'(idle_field[FIELD_W-2:0]);
        idle_lim   = idle_field[FIELD_W-1] ? (idle_base << IDLE_X4_SHIFT) : idle_base;
        lines_high = scl & sda;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_SETTLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_SETTLE: begin
                if (start_det)             state_d = BS_BUSY;
                else if (!lines_high)      state_d = BS_HUNT;
                else if (idle_cnt >= idle_lim) state_d = BS_FREE;
            end
            BS_FREE: begin
                if (start_det)             state_d = BS_BUSY;
                else if (!lines_high)      state_d = BS_HUNT;
            end
            BS_BUSY: begin
                if (stop_det)              state_d = BS_SETTLE;
            end
            BS_HUNT: begin
                if (start_det)             state_d = BS_BUSY;
                else if (stop_det)         state_d = BS_SETTLE;
            end
            default:                       state_d = BS_HUNT;
        endcase
    end

    // quiet-time counter, only alive in SETTLE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idle_cnt <= '0;
        else if (state_q != BS_SETTLE)
            idle_cnt <= '0;
        else if (tick && (idle_cnt < idle_lim))
            idle_cnt <= idle_cnt + 1'b1;
    end

    // outputs
    always_comb begin
        bus_free = (state_q == BS_FREE) & lines_high;
        busy     = (state_q == BS_BUSY);
    end
endmodule

// File: rtl/smb_cum_timer.sv
`timescale 1ns/1ps
module smb_cum_timer
    import smb_mon_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int SHIFT   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run,
    input  logic               restart,
    input  logic [FIELD_W-1:0] field,
    output logic               expire
);
    localparam int CW = FIELD_W + SHIFT;

    tmr_state_e    st_q;
    tmr_state_e    st_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] limit;
    logic          enabled;
    logic          fire;

    always_comb begin
        limit   = {field, {SHIFT{1'b0}}};
        enabled = (field != '0);
        cnt_inc = cnt_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TM_ARMED;
            cnt_q  <= '0;
            expire <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            expire <= fire;
        end
    end

    // next state and count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        fire  = 1'b0;
        if (restart) begin
            st_d  = TM_ARMED;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                TM_ARMED: begin
                    if (run && tick && enabled) begin
                        cnt_d = cnt_inc;
                        if (cnt_inc >= limit) begin
                            st_d = TM_SPENT;
                            fire = 1'b1;
                        end
                    end
                end
                TM_SPENT: st_d = TM_SPENT;
                default:  st_d = TM_ARMED;
            endcase
        end
    end
endmodule

// File: rtl/smb_flag_bank.sv
`timescale 1ns/1ps
module smb_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    // a new event outranks a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end
endmodule

// File: rtl/smb_tmo_mon.sv
`timescale 1ns/1ps
module smb_tmo_mon
    import smb_mon_pkg::*;
#(
    parameter  int FIELD_W       = 8,
    parameter  int CTL_SHIFT     = 11,
    parameter  int TGT_SHIFT     = 12,
    parameter  int HIGH_SHIFT    = 3,
    parameter  int IDLE_X4_SHIFT = 2,
    localparam int CFG_W         = 4 * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               ctl_scl_low,
    input  logic [NUM_TMO-1:0] flag_clr,
    output logic               bus_free,
    output logic [NUM_TMO-1:0] tmo_irq,
    output logic [NUM_TMO-1:0] tmo_flag
);
    logic               start_det;
    logic               stop_det;
    logic               busy;
    logic [NUM_TMO-1:0] run_v;
    logic [NUM_TMO-1:0] restart_v;

    smb_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_in),
        .sda       (sda_in),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_bus_fsm #(
        .FIELD_W       (FIELD_W),
        .IDLE_X4_SHIFT (IDLE_X4_SHIFT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .scl        (scl_in),
        .sda        (sda_in),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .idle_field (cfg_word[3*FIELD_W +: FIELD_W]),
        .bus_free   (bus_free),
        .busy       (busy)
    );

    // who is charged for the current clock phase
    always_comb begin
        run_v[CH_CTL]      = busy & ~scl_in & ctl_scl_low;
        run_v[CH_TGT]      = busy & ~scl_in & ~ctl_scl_low;
        run_v[CH_HIGH]     = busy & scl_in;
        restart_v[CH_CTL]  = start_det | stop_det;
        restart_v[CH_TGT]  = start_det | stop_det;
        restart_v[CH_HIGH] = start_det | stop_det | ~scl_in;
    end

    for (genvar g = 0; g < NUM_TMO; g++) begin : g_tmr
        localparam int SH = (g == CH_CTL) ? CTL_SHIFT :
                            ((g == CH_TGT) ? TGT_SHIFT : HIGH_SHIFT);
        smb_cum_timer #(
            .FIELD_W (FIELD_W),
            .SHIFT   (SH)
        ) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_en),
            .run     (run_v[g]),
            .restart (restart_v[g]),
            .field   (cfg_word[(NUM_TMO-1-g)*FIELD_W +: FIELD_W]),
            .expire  (tmo_irq[g])
        );
    end

    smb_flag_bank #(.N(NUM_TMO)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (tmo_irq),
        .clr   (flag_clr),
        .flags (tmo_flag)
    );
endmodule

// File: rtl/smb_tmo_mon_chk.sv
`timescale 1ns/1ps
module smb_tmo_mon_chk
    import smb_mon_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               scl_in,
    input logic               sda_in,
    input logic               bus_free,
    input logic [NUM_TMO-1:0] flag_clr,
    input logic [NUM_TMO-1:0] tmo_irq,
    input logic [NUM_TMO-1:0] tmo_flag
);
    // R4: a low line and a free bus never coexist
    p_low_line_blocks_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_in || !sda_in) |-> !bus_free);

    // R2: the bus only turns free after a cycle with both lines high
    p_free_after_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> $past(scl_in && sda_in));

    // R5: every timeout pulse is a single cycle wide
    p_irq_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmo_irq) |=> ((tmo_irq & $past(tmo_irq)) == '0));

    // R11: a pulse always leaves its flag set on the next edge
    p_irq_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmo_irq) |=> ((tmo_flag & $past(tmo_irq)) == $past(tmo_irq)));

    // R11: a flag only drops after a clear strobe
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmo_flag) |=> ((~tmo_flag & $past(tmo_flag) & ~$past(flag_clr)) == '0));
endmodule

bind smb_tmo_mon smb_tmo_mon_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .bus_free (bus_free),
    .flag_clr (flag_clr),
    .tmo_irq  (tmo_irq),
    .tmo_flag (tmo_flag)
);

// File: tb/sim_smb_tmo_mon.sv
`timescale 1ns/1ps
module sim_smb_tmo_mon;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic [31:0] cfg_word;
    logic        scl_in;
    logic        sda_in;
    logic        ctl_scl_low;
    logic [2:0]  flag_clr;
    logic        bus_free;
    logic [2:0]  tmo_irq;
    logic [2:0]  tmo_flag;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    smb_tmo_mon u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .cfg_word    (cfg_word),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .ctl_scl_low (ctl_scl_low),
        .flag_clr    (flag_clr),
        .bus_free    (bus_free),
        .tmo_irq     (tmo_irq),
        .tmo_flag    (tmo_flag)
    );

    // idle field and expected sample count from STOP edge to bus_free (L+2)
    localparam logic [15:0] IDLE_VEC [6] = '{
        {8'h00, 8'd2}, {8'h01, 8'd3}, {8'h06, 8'd8},
        {8'h82, 8'd10}, {8'h85, 8'd22}, {8'h90, 8'd66}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [7:0] idl, input logic [7:0] ctl,
                           input logic [7:0] tgt, input logic [7:0] hi);
        cfg_word = {idl, ctl, tgt, hi};
    endtask

    task automatic start_cond();
        sda_in = 1'b0;
        step(1);
    endtask

    task automatic stop_cond();
        ctl_scl_low = 1'b0;
        scl_in = 1'b0;
        sda_in = 1'b0;
        step(1);
        scl_in = 1'b1;
        step(1);
        sda_in = 1'b1;
    endtask

    task automatic wipe();
        step(1);
        flag_clr = 3'b111;
        step(1);
        flag_clr = 3'b000;
    endtask

    task automatic wait_free(output int n);
        n = 0;
        while (!bus_free && n < 600) begin
            step(1);
            n++;
        end
    endtask

    initial begin
        int n;
        rst_n = 1'b0; tick_en = 1'b1; scl_in = 1'b1; sda_in = 1'b1;
        ctl_scl_low = 1'b0; flag_clr = 3'b000;
        set_cfg(8'h00, 8'h00, 8'h00, 8'h00);
        step(3);
        check("R12 reset bus_free", bus_free, 0);
        check("R12 reset irq", tmo_irq, 0);
        check("R12 reset flags", tmo_flag, 0);
        rst_n = 1'b1;
        step(3);
        check("R12 free after reset", bus_free, 1);

        // R1 R2: idle-limit table
        foreach (IDLE_VEC[i]) begin
            set_cfg(IDLE_VEC[i][15:8], 8'h00, 8'h00, 8'h00);
            start_cond();
            check("R2 busy after START", bus_free, 0);
            stop_cond();
            wait_free(n);
            check("R1 R2 idle time", n, IDLE_VEC[i][7:0]);
        end

        // R4 immediate drop, R3 hunt
        set_cfg(8'h00, 8'h00, 8'h00, 8'h00);
        scl_in = 1'b0;
        #1;
        check("R4 drop on SCL low", bus_free, 0);
        step(1);
        scl_in = 1'b1;
        step(20);
        check("R3 hunt keeps bus taken", bus_free, 0);
        stop_cond();
        wait_free(n);
        check("R3 free after STOP", bus_free, 1);
        sda_in = 1'b0;
        #1;
        check("R4 drop on START", bus_free, 0);
        step(1);
        stop_cond();
        wait_free(n);

        // R5 controller cumulative with an SCL-high gap, R11 set beats clear
        set_cfg(8'h00, 8'h01, 8'h00, 8'h00);
        start_cond();
        scl_in = 1'b0; ctl_scl_low = 1'b1;
        step(1500);
        scl_in = 1'b1;
        step(10);
        scl_in = 1'b0;
        step(547);
        check("R5 no pulse at 2047", tmo_irq, 3'b000);
        step(1);
        check("R5 pulse at 2048", tmo_irq, 3'b001);
        flag_clr = 3'b001;
        step(1);
        check("R11 set wins over clear", tmo_flag, 3'b001);
        step(1);
        check("R11 write-1 clears", tmo_flag, 3'b000);
        flag_clr = 3'b000;

        // R8 STOP/START restart the cumulative count
        stop_cond();
        step(1);
        start_cond();
        scl_in = 1'b0; ctl_scl_low = 1'b1;
        step(1500);
        stop_cond();
        step(1);
        start_cond();
        scl_in = 1'b0; ctl_scl_low = 1'b1;
        step(2047);
        check("R8 count restarted", tmo_flag, 3'b000);
        step(1);
        check("R8 fires 2048 after restart", tmo_irq, 3'b001);
        wipe();

        // R6 target cumulative, no charge to controller
        stop_cond();
        step(1);
        set_cfg(8'h00, 8'h01, 8'h01, 8'h00);
        start_cond();
        scl_in = 1'b0; ctl_scl_low = 1'b0;
        step(4095);
        check("R6 no pulse at 4095", tmo_irq, 3'b000);
        step(1);
        check("R6 target pulse, controller idle", tmo_irq, 3'b010);
        wipe();

        // R7 clock-high timeout and restart on low
        stop_cond();
        step(1);
        set_cfg(8'h00, 8'h00, 8'h00, 8'h03);
        start_cond();
        step(23);
        check("R7 no pulse at 23", tmo_irq, 3'b000);
        step(1);
        check("R7 pulse at 24", tmo_irq, 3'b100);
        wipe();
        scl_in = 1'b0;
        step(1);
        scl_in = 1'b1;
        step(20);
        scl_in = 1'b0;
        step(1);
        scl_in = 1'b1;
        step(23);
        check("R7 low restarts count", tmo_flag, 3'b000);
        step(1);
        check("R7 pulse after restart", tmo_irq, 3'b100);
        wipe();

        // R10 ticks gate counting
        set_cfg(8'h00, 8'h00, 8'h00, 8'h01);
        tick_en = 1'b0;
        scl_in = 1'b0;
        step(1);
        scl_in = 1'b1;
        step(50);
        check("R10 no count without tick", tmo_flag, 3'b000);
        tick_en = 1'b1;
        step(7);
        check("R10 seven ticks", tmo_irq, 3'b000);
        step(1);
        check("R10 eighth tick fires", tmo_irq, 3'b100);
        wipe();

        // R9 zero fields disable
        set_cfg(8'h00, 8'h00, 8'h00, 8'h00);
        scl_in = 1'b0;
        step(1);
        scl_in = 1'b1;
        step(300);
        scl_in = 1'b0; ctl_scl_low = 1'b1;
        step(300);
        ctl_scl_low = 1'b0;
        step(300);
        check("R9 zero disables", tmo_flag, 3'b000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule